// File: doc/BRIEF.md
# E1 Multiframe Alignment Monitor

The monitor sits behind a basic frame aligner on an E1 receive path. The aligner already knows where each 256-bit frame starts and whether a frame carries the frame alignment signal or not. For each received frame it hands over the time slot 0 octet and the time slot 16 octet, together with a one-cycle frame strobe. A separate CRC-4 checker raises a strobe at the end of each CRC-4 codeword and says whether that codeword was in error.

Two independent state machines sit on these inputs. The CRC-4 machine searches for the CRC-4 multiframe alignment word, confirms it, and holds alignment until the codeword error rate shows that the alignment is wrong. Its states are HUNT, CONFIRM and LOCKED. The transitions are: HUNT to CONFIRM on the first word; CONFIRM to LOCKED on a second word in phase inside the window; CONFIRM to HUNT when the window runs out; and LOCKED to HUNT when an error block fails. The signalling (CAS) machine searches for the signalling multiframe word in time slot 16 and holds alignment until two words in a row are corrupted. Its states are HUNT, LOCKED and SUSPECT. The transitions are: HUNT to LOCKED on a word that follows a non-zero slot; LOCKED to SUSPECT on one bad word; SUSPECT back to LOCKED on a good word; and SUSPECT to HUNT on a second bad word. When basic frame alignment is lost, both machines go to HUNT. Each machine reports a sync flag and a 0 to 15 frame number within its multiframe.

Top module: `e1_mfa_monitor`

## Requirements
- R1: In HUNT, a frame with `frame_strobe`=1 and `nfas_frame`=1 is a CRC-4 word hit when its Si bit (`ts0_octet[7]`) completes the pattern 0,0,1,0,1,1 over the last six non-alignment frames, oldest first. A hit moves the machine to CONFIRM and loads `crc_mf_frame` with 11, while `crc_mf_sync` stays 0.
- R2: In CONFIRM, a second word hit at a frame whose number becomes 11, less than WINDOW_FRAMES (64) frames after the first hit, moves the machine to LOCKED. `crc_mf_sync` goes to 1 at the clock edge that takes that frame.
- R3: In CONFIRM, if WINDOW_FRAMES strobed frames pass since the first hit without a confirming hit, the machine returns to HUNT. A word arriving exactly WINDOW_FRAMES frames later does not lock, and it does not count as a new first hit.
- R4: In LOCKED, `cw_strobe` pulses are counted in blocks of CW_BLOCK codewords, and `cw_err`=1 marks an errored codeword. At the last codeword of a block, a total of CW_ERR_LIMIT or more errors returns the machine to HUNT, with `crc_mf_sync` going to 0 at that edge. A smaller total keeps the machine in LOCKED and starts a new block.
- R5: In CAS HUNT, a strobed frame with `ts16_octet[7:4]`=0000 locks the CAS machine only if the previous strobed frame's `ts16_octet` was non-zero. The lock sets `cas_mf_sync`=1 and `cas_mf_frame`=0.
- R6: While CAS is aligned, the frame whose number wraps to 0 must carry `ts16_octet[7:4]`=0000. One bad word moves the machine to SUSPECT, and the flag stays 1. A good word in SUSPECT returns it to LOCKED. A second consecutive bad word returns it to HUNT, and the flag goes to 0.
- R7: Each frame counter advances by one, modulo 16, on every strobed frame, except when its machine loads it on a hit in HUNT.
- R8: While `frame_locked`=0, both machines are forced to HUNT at the next edge. Both flags and both counters become 0, the Si history and the previous-slot record are cleared, and strobes are ignored.
- R9: After reset, both flags are 0 and both frame counters are 0.
- R10: In a cycle with `frame_strobe`=0 and `cw_strobe`=0, the values on `ts0_octet`, `ts16_octet`, `nfas_frame` and `cw_err` change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_locked | input | 1 | Basic frame alignment is held |
| frame_strobe | input | 1 | One pulse per received frame; qualifies the octet inputs |
| nfas_frame | input | 1 | 1 for a frame that does not carry the frame alignment signal |
| ts0_octet | input | 8 | Time slot 0 octet; bit 7 is the Si bit |
| ts16_octet | input | 8 | Time slot 16 octet |
| cw_strobe | input | 1 | End of one CRC-4 codeword |
| cw_err | input | 1 | Codeword in error, qualified by cw_strobe |
| crc_mf_sync | output | 1 | CRC-4 multiframe alignment held |
| crc_mf_frame | output | 4 | Frame number within the CRC-4 multiframe |
| cas_mf_sync | output | 1 | Signalling multiframe alignment held |
| cas_mf_frame | output | 4 | Frame number within the signalling multiframe |

## Verification
The bench builds the monitor with WINDOW_FRAMES=64, CW_BLOCK=20 and CW_ERR_LIMIT=18. The window keeps its real length, so the expiry at exactly 64 frames and the confirmations at 16, 32 and 48 frames are tested as the line would present them. The short codeword block makes it quick to test both sides of the error threshold: a block with one error too few keeps alignment, and a block that just reaches the limit drops it. Because the block is short, the random phase can also reach block failures many times, where the default of 1000 codewords would need thousands of strobes per evaluation.

// File: rtl/e1_mfa_pkg.sv
package e1_mfa_pkg;

    localparam int MF_FRAMES = 16;
    localparam int FNUM_W = $clog2(MF_FRAMES);

    // Si bits of frames 1,3,5,7,9,11, oldest in the MSB
    localparam logic [5:0] CRC_WORD = 6'b001011;
    localparam logic [FNUM_W-1:0] CRC_WORD_LAST = FNUM_W'(11);
    localparam logic [3:0] CAS_WORD = 4'b0000;

    typedef enum logic [1:0] {
        CRC_HUNT    = 2'd0,
        CRC_CONFIRM = 2'd1,
        CRC_LOCKED  = 2'd2
    } crc_state_t;

    typedef enum logic [1:0] {
        CAS_HUNT    = 2'd0,
        CAS_LOCKED  = 2'd1,
        CAS_SUSPECT = 2'd2
    } cas_state_t;

endpackage

// File: rtl/e1_cw_error_monitor.sv
module e1_cw_error_monitor
    import e1_mfa_pkg::*;
#(
    parameter int CW_BLOCK     = 1000,
    parameter int CW_ERR_LIMIT = 915
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cw_strobe,
    input  logic cw_err,
    output logic block_fail
);
    localparam int CNT_W = (CW_BLOCK > 1) ? $clog2(CW_BLOCK) : 1;
    localparam int ERR_W = $clog2(CW_BLOCK + 1);

    logic [CNT_W-1:0] cw_cnt;
    logic [ERR_W-1:0] err_cnt;
    logic [ERR_W-1:0] err_total;
    logic             block_end;

    always_comb begin
        err_total  = err_cnt + ERR_W'(cw_err);
        block_end  = enable && cw_strobe && (cw_cnt == CNT_W'(CW_BLOCK - 1));
        block_fail = block_end && (err_total >= ERR_W'(CW_ERR_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cw_cnt  <= '0;
            err_cnt <= '0;
        end else if (cw_strobe) begin
            if (block_end) begin
                cw_cnt  <= '0;
                err_cnt <= '0;
            end else begin
                cw_cnt  <= cw_cnt + 1'b1;
                err_cnt <= err_total;
            end
        end
    end

endmodule

// File: rtl/e1_crc_mf_tracker.sv
module e1_crc_mf_tracker
    import e1_mfa_pkg::*;
#(
    parameter int WINDOW_FRAMES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_locked,
    input  logic              frame_strobe,
    input  logic              nfas_frame,
    input  logic              si_bit,
    input  logic              block_fail,
    output logic              crc_sync,
    output logic [FNUM_W-1:0] crc_frame
);
    localparam int WIN_W = $clog2(WINDOW_FRAMES + 1);

    crc_state_t        state, state_nx;
    logic [5:0]        si_hist;
    logic [5:0]        hist_nx;
    logic [FNUM_W-1:0] fcnt;
    logic [FNUM_W-1:0] fcnt_nx;
    logic [WIN_W-1:0]  win_cnt;
    logic [WIN_W-1:0]  win_nx;
    logic              word_hit;
    logic              in_phase;
    logic              win_open;

    always_comb begin
        hist_nx  = {si_hist[4:0], si_bit};
        word_hit = frame_strobe && nfas_frame && (hist_nx == CRC_WORD);
        fcnt_nx  = fcnt + 1'b1;
        in_phase = (fcnt_nx == CRC_WORD_LAST);
        win_nx   = win_cnt + 1'b1;
        win_open = (win_nx < WIN_W'(WINDOW_FRAMES));
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!frame_locked) begin
            state_nx = CRC_HUNT;
        end else begin
            unique case (state)
                CRC_HUNT: begin
                    if (word_hit) state_nx = CRC_CONFIRM;
                end
                CRC_CONFIRM: begin
                    if (frame_strobe) begin
                        if (in_phase && word_hit && win_open) state_nx = CRC_LOCKED;
                        else if (!win_open)                   state_nx = CRC_HUNT;
                    end
                end
                CRC_LOCKED: begin
                    if (block_fail) state_nx = CRC_HUNT;
                end
                default: state_nx = CRC_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CRC_HUNT;
        else        state <= state_nx;
    end

    // frame counter, Si history and window counter
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_locked) begin
            si_hist <= '1;
            fcnt    <= '0;
            win_cnt <= '0;
        end else if (frame_strobe) begin
            if (nfas_frame) si_hist <= hist_nx;
            if (state == CRC_HUNT && word_hit) fcnt <= CRC_WORD_LAST;
            else                               fcnt <= fcnt_nx;
            win_cnt <= (state == CRC_CONFIRM) ? win_nx : '0;
        end
    end

    // outputs
    always_comb begin
        crc_sync  = (state == CRC_LOCKED);
        crc_frame = fcnt;
    end

endmodule

// File: rtl/e1_cas_mf_tracker.sv
module e1_cas_mf_tracker
    import e1_mfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_locked,
    input  logic              frame_strobe,
    input  logic [7:0]        ts16,
    output logic              cas_sync,
    output logic [FNUM_W-1:0] cas_frame
);
    cas_state_t        state, state_nx;
    logic [7:0]        prev_ts16;
    logic [FNUM_W-1:0] fcnt;
    logic [FNUM_W-1:0] fcnt_nx;
    logic              word_ok;
    logic              at_start;
    logic              lock_hit;

    always_comb begin
        word_ok  = (ts16[7:4] == CAS_WORD);
        fcnt_nx  = fcnt + 1'b1;
        at_start = (fcnt_nx == '0);
        lock_hit = frame_strobe && word_ok && (prev_ts16 != 8'h00);
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!frame_locked) begin
            state_nx = CAS_HUNT;
        end else begin
            unique case (state)
                CAS_HUNT: begin
                    if (lock_hit) state_nx = CAS_LOCKED;
                end
                CAS_LOCKED: begin
                    if (frame_strobe && at_start && !word_ok) state_nx = CAS_SUSPECT;
                end
                CAS_SUSPECT: begin
                    if (frame_strobe && at_start)
                        state_nx = word_ok ? CAS_LOCKED : CAS_HUNT;
                end
                default: state_nx = CAS_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CAS_HUNT;
        else        state <= state_nx;
    end

    // frame counter and previous slot record
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_locked) begin
            prev_ts16 <= '0;
            fcnt      <= '0;
        end else if (frame_strobe) begin
            prev_ts16 <= ts16;
            if (state == CAS_HUNT && lock_hit) fcnt <= '0;
            else                               fcnt <= fcnt_nx;
        end
    end

    // outputs
    always_comb begin
        cas_sync  = (state == CAS_LOCKED) || (state == CAS_SUSPECT);
        cas_frame = fcnt;
    end

endmodule

// File: rtl/e1_mfa_monitor.sv
module e1_mfa_monitor
    import e1_mfa_pkg::*;
#(
    parameter int WINDOW_FRAMES = 64,
    parameter int CW_BLOCK      = 1000,
    parameter int CW_ERR_LIMIT  = 915
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_locked,
    input  logic       frame_strobe,
    input  logic       nfas_frame,
    input  logic [7:0] ts0_octet,
    input  logic [7:0] ts16_octet,
    input  logic       cw_strobe,
    input  logic       cw_err,
    output logic       crc_mf_sync,
    output logic [3:0] crc_mf_frame,
    output logic       cas_mf_sync,
    output logic [3:0] cas_mf_frame
);
    logic block_fail;
    logic mon_enable;

    assign mon_enable = crc_mf_sync && frame_locked;

    e1_cw_error_monitor #(
        .CW_BLOCK     (CW_BLOCK),
        .CW_ERR_LIMIT (CW_ERR_LIMIT)
    ) u_errmon (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (mon_enable),
        .cw_strobe  (cw_strobe),
        .cw_err     (cw_err),
        .block_fail (block_fail)
    );

    e1_crc_mf_tracker #(
        .WINDOW_FRAMES (WINDOW_FRAMES)
    ) u_crc (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_locked (frame_locked),
        .frame_strobe (frame_strobe),
        .nfas_frame   (nfas_frame),
        .si_bit       (ts0_octet[7]),
        .block_fail   (block_fail),
        .crc_sync     (crc_mf_sync),
        .crc_frame    (crc_mf_frame)
    );

    e1_cas_mf_tracker u_cas (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_locked (frame_locked),
        .frame_strobe (frame_strobe),
        .ts16         (ts16_octet),
        .cas_sync     (cas_mf_sync),
        .cas_frame    (cas_mf_frame)
    );

endmodule

// File: rtl/e1_mfa_monitor_checker.sv
module e1_mfa_monitor_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_locked,
    input logic       frame_strobe,
    input logic       nfas_frame,
    input logic [7:0] ts16_octet,
    input logic       cw_strobe,
    input logic       crc_mf_sync,
    input logic [3:0] crc_mf_frame,
    input logic       cas_mf_sync,
    input logic [3:0] cas_mf_frame
);
    assert_crc_lock_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_mf_sync) |-> $past(frame_strobe && frame_locked && nfas_frame));

    assert_crc_lock_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_mf_sync) |-> (crc_mf_frame == 4'd11));

    assert_cas_lock_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_mf_sync) |-> (($past(ts16_octet[7:4]) == 4'd0) && (cas_mf_frame == 4'd0)));

    assert_unlock_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_locked |=> (!crc_mf_sync && !cas_mf_sync && crc_mf_frame == 4'd0 && cas_mf_frame == 4'd0));

    assert_crc_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_mf_sync && frame_strobe && frame_locked) |=> (crc_mf_frame == $past(crc_mf_frame) + 4'd1));

    assert_cas_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_mf_sync && frame_strobe && frame_locked) |=> (cas_mf_frame == $past(cas_mf_frame) + 4'd1));

    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_locked && !frame_strobe && !cw_strobe) |=>
            ($stable(crc_mf_sync) && $stable(cas_mf_sync) && $stable(crc_mf_frame) && $stable(cas_mf_frame)));

endmodule

bind e1_mfa_monitor e1_mfa_monitor_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_locked (frame_locked),
    .frame_strobe (frame_strobe),
    .nfas_frame   (nfas_frame),
    .ts16_octet   (ts16_octet),
    .cw_strobe    (cw_strobe),
    .crc_mf_sync  (crc_mf_sync),
    .crc_mf_frame (crc_mf_frame),
    .cas_mf_sync  (cas_mf_sync),
    .cas_mf_frame (cas_mf_frame)
);

// File: tb/e1_mfa_monitor_test.sv
module e1_mfa_monitor_test;
    localparam int WIN = 64;
    localparam int CWB = 20;
    localparam int LIM = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_locked = 1'b0;
    logic       frame_strobe = 1'b0;
    logic       nfas_frame = 1'b0;
    logic [7:0] ts0_octet = 8'h00;
    logic [7:0] ts16_octet = 8'h00;
    logic       cw_strobe = 1'b0;
    logic       cw_err = 1'b0;
    logic       crc_mf_sync;
    logic [3:0] crc_mf_frame;
    logic       cas_mf_sync;
    logic [3:0] cas_mf_frame;

    int total = 0;
    int bad = 0;

    // reference state
    int m_crc, m_cnt, m_win, m_cas, m_ccnt, m_cwc, m_errc;
    logic [5:0] m_hist;
    logic [7:0] m_prev;
    // stream position
    int crc_pos, cas_pos;

    always #10 clk = ~clk;

    e1_mfa_monitor #(
        .WINDOW_FRAMES (WIN),
        .CW_BLOCK      (CWB),
        .CW_ERR_LIMIT  (LIM)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_locked (frame_locked),
        .frame_strobe (frame_strobe),
        .nfas_frame   (nfas_frame),
        .ts0_octet    (ts0_octet),
        .ts16_octet   (ts16_octet),
        .cw_strobe    (cw_strobe),
        .cw_err       (cw_err),
        .crc_mf_sync  (crc_mf_sync),
        .crc_mf_frame (crc_mf_frame),
        .cas_mf_sync  (cas_mf_sync),
        .cas_mf_frame (cas_mf_frame)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic si_of(input int pos, input bit corrupt);
        logic [5:0] pat = 6'b001011;
        if (pos % 2 == 0) return 1'($urandom_range(0, 1));
        if (pos > 11) return 1'b1;
        if (pos == 11 && corrupt) return 1'b0;
        return pat[5 - (pos - 1) / 2];
    endfunction

    function automatic logic [7:0] ts16_of(input int pos, input bit corrupt);
        logic [3:0] hi = 4'($urandom_range(1, 15));
        if (pos == 0 && !corrupt) hi = 4'h0;
        return {hi, 4'($urandom_range(0, 15))};
    endfunction

    // reference update, from the requirements
    task automatic model(input logic lk, st, nf, input logic [7:0] t0, t16,
                         input logic cs, ce);
        logic [5:0] hn;
        bit seen, fail, wok, lockc;
        int ns, nc;
        hn = {m_hist[4:0], t0[7]};
        seen = st && nf && (hn == 6'b001011);
        fail = 0;
        if (m_crc == 2 && lk) begin
            if (cs) begin
                if (m_cwc == CWB - 1) begin
                    fail = (m_errc + int'(ce)) >= LIM;
                    m_cwc = 0; m_errc = 0;
                end else begin
                    m_cwc++; m_errc += int'(ce);
                end
            end
        end else begin
            m_cwc = 0; m_errc = 0;
        end
        if (!lk) begin
            m_crc = 0; m_hist = 6'h3f; m_cnt = 0; m_win = 0;
            m_cas = 0; m_prev = 8'h00; m_ccnt = 0;
        end else begin
            ns = m_crc;
            case (m_crc)
                0: if (seen) ns = 1;
                1: if (st) begin
                       if ((m_cnt + 1) % 16 == 11 && seen && m_win + 1 < WIN) ns = 2;
                       else if (m_win + 1 >= WIN) ns = 0;
                   end
                default: if (fail) ns = 0;
            endcase
            if (st) begin
                if (nf) m_hist = hn;
                m_cnt = (m_crc == 0 && seen) ? 11 : (m_cnt + 1) % 16;
                m_win = (m_crc == 1) ? m_win + 1 : 0;
            end
            m_crc = ns;
            wok = (t16[7:4] == 4'h0);
            nc = (m_ccnt + 1) % 16;
            lockc = st && wok && (m_prev != 8'h00);
            ns = m_cas;
            case (m_cas)
                0: if (lockc) ns = 1;
                1: if (st && nc == 0 && !wok) ns = 2;
                default: if (st && nc == 0) ns = wok ? 1 : 0;
            endcase
            if (st) begin
                m_ccnt = (m_cas == 0 && lockc) ? 0 : nc;
                m_prev = t16;
            end
            m_cas = ns;
        end
    endtask

    task automatic tick(input logic lk, st, nf, input logic [7:0] t0, t16,
                        input logic cs, ce, input string tag);
        frame_locked = lk; frame_strobe = st; nfas_frame = nf;
        ts0_octet = t0; ts16_octet = t16; cw_strobe = cs; cw_err = ce;
        model(lk, st, nf, t0, t16, cs, ce);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " crc_sync"}, int'(crc_mf_sync), int'(m_crc == 2));
        chk({tag, " crc_frame"}, int'(crc_mf_frame), m_cnt);
        chk({tag, " cas_sync"}, int'(cas_mf_sync), int'(m_cas != 0));
        chk({tag, " cas_frame"}, int'(cas_mf_frame), m_ccnt);
    endtask

    task automatic frame(input bit bad_crc, bad_cas, input logic cs, ce, input string tag);
        logic [7:0] t0 = {si_of(crc_pos, bad_crc), 7'($urandom_range(0, 127))};
        logic [7:0] t16 = ts16_of(cas_pos, bad_cas);
        tick(1'b1, 1'b1, 1'(crc_pos % 2), t0, t16, cs, ce, tag);
        crc_pos = (crc_pos + 1) % 16;
        cas_pos = (cas_pos + 1) % 16;
    endtask

    task automatic unlock(input string tag);
        tick(1'b0, 1'b1, 1'b1, 8'hff, 8'h00, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(20ns * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_crc = 0; m_cnt = 0; m_win = 0; m_cas = 0; m_ccnt = 0;
        m_cwc = 0; m_errc = 0; m_hist = 6'h3f; m_prev = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        frame_locked = 1'b1;
        @(negedge clk);
        chk("R9 crc_sync", int'(crc_mf_sync), 0);
        chk("R9 crc_frame", int'(crc_mf_frame), 0);
        chk("R9 cas_sync", int'(cas_mf_sync), 0);
        chk("R9 cas_frame", int'(cas_mf_frame), 0);

        // acquisition from an arbitrary phase
        crc_pos = 3; cas_pos = 9;
        for (int i = 0; i < 60; i++) frame(0, 0, 1'b0, 1'b0, "R2");
        chk("R2 locked after stream", int'(crc_mf_sync), 1);
        chk("R5 cas locked after stream", int'(cas_mf_sync), 1);

        // loss of basic alignment
        unlock("R8");
        chk("R8 crc cleared", int'(crc_mf_sync), 0);
        chk("R8 cas cleared", int'(cas_mf_sync), 0);

        // first word then confirmation 16 frames later
        crc_pos = 0;
        for (int i = 0; i < 12; i++) frame(0, 0, 1'b0, 1'b0, "R1");
        chk("R1 first word frame", int'(crc_mf_frame), 11);
        chk("R1 first word no sync", int'(crc_mf_sync), 0);
        for (int i = 0; i < 16; i++) frame(0, 0, 1'b0, 1'b0, "R2");
        chk("R2 second word sync", int'(crc_mf_sync), 1);

        // window expiry
        unlock("R8");
        crc_pos = 0;
        for (int i = 0; i < 12; i++) frame(0, 0, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 48; i++) frame(1, 0, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 16; i++) frame(0, 0, 1'b0, 1'b0, "R3");
        chk("R3 word at window end", int'(crc_mf_sync), 0);
        for (int i = 0; i < 16; i++) frame(0, 0, 1'b0, 1'b0, "R3");
        chk("R3 new first word", int'(crc_mf_sync), 0);
        for (int i = 0; i < 16; i++) frame(0, 0, 1'b0, 1'b0, "R3");
        chk("R3 relock", int'(crc_mf_sync), 1);

        // codeword error blocks
        for (int i = 0; i < CWB; i++)
            tick(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'(i < LIM - 1), "R4");
        chk("R4 below limit keeps sync", int'(crc_mf_sync), 1);
        for (int i = 0; i < CWB - 1; i++)
            tick(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'(i < LIM - 1), "R4");
        chk("R4 before block end", int'(crc_mf_sync), 1);
        tick(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, "R4");
        chk("R4 limit reached drops", int'(crc_mf_sync), 0);

        // CAS maintenance
        for (int i = 0; i < 16; i++) frame(0, 1, 1'b0, 1'b0, "R6");
        chk("R6 one bad word keeps sync", int'(cas_mf_sync), 1);
        for (int i = 0; i < 16; i++) frame(0, 0, 1'b0, 1'b0, "R6");
        chk("R6 recovered", int'(cas_mf_sync), 1);
        for (int i = 0; i < 32; i++) frame(0, 1, 1'b0, 1'b0, "R6");
        chk("R6 two bad words drop", int'(cas_mf_sync), 0);

        // preceding slot must be non-zero
        unlock("R8");
        tick(1'b1, 1'b1, 1'b0, 8'h1b, 8'h05, 1'b0, 1'b0, "R5");
        chk("R5 zero previous slot no lock", int'(cas_mf_sync), 0);
        tick(1'b1, 1'b1, 1'b1, 8'h40, 8'h3a, 1'b0, 1'b0, "R5");
        tick(1'b1, 1'b1, 1'b0, 8'h1b, 8'h05, 1'b0, 1'b0, "R5");
        chk("R5 lock after non-zero slot", int'(cas_mf_sync), 1);
        chk("R5 lock frame zero", int'(cas_mf_frame), 0);

        // constrained random mix
        crc_pos = 0;
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 99));
            logic cs = 1'($urandom_range(0, 3) == 0);
            logic ce = 1'($urandom_range(0, 9) != 0);
            if (r < 60)
                frame(1'($urandom_range(0, 19) == 0), 1'($urandom_range(0, 19) == 0), cs, ce, "R7");
            else if (r < 80)
                tick(1'b1, 1'b0, 1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom),
                     1'b0, 1'($urandom_range(0, 1)), "R10");
            else if (r < 99)
                tick(1'b1, 1'b0, 1'b0, 8'($urandom), 8'($urandom), 1'b1, ce, "R4");
            else
                unlock("R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule